// File: doc/BRIEF.md
# Cascaded Two-Stage Interrupt Vector Controller

This block joins two 8-input interrupt controllers, a primary and a secondary, so that 16 request lines share one interrupt output toward the processor. Each controller is set up by byte writes: a command write at its command address opens initialization. Writes at its data address then supply the vector base, then a link word, and after that the line mask. Requests latch on rising edges. Each controller resolves them with a fixed priority, and the secondary's output is wired into input 2 of the primary.

The processor answers a raised `int_out` with two acknowledge pulses on `inta`. The first marks the winning level in service and clears its request latch; nothing is driven on the bus. One cycle after the second pulse, `vec_valid` rises for a single cycle with the vector on `vec_out`. Bits [7:3] of the vector are the programmed base and bits [2:0] are the level code. When the primary's input 2 wins, the returned vector is the secondary's base together with the secondary's own level code.

Top module: `cascade_pic_top`

## Requirements
- R1: After reset, `int_out` and `vec_valid` are 0. A controller raises no interrupt and latches no request edge until its initialization sequence has completed.
- R2: A write with bit 4 set to the command address (0x20 primary, 0xA0 secondary) starts initialization and clears that controller's mask, request and in-service state. The next data-address write (0x21 primary, 0xA1 secondary) stores bits [7:3] as the vector base; bits [2:0] of that write are discarded. The following data write is the link word. Every data write after that loads the mask.
- R3: A request is latched only by a rising edge on its line. A line held high after its interrupt has been acknowledged does not request again.
- R4: Within a controller, line 0 has the highest priority and line 7 the lowest. An unmasked pending line wins only if it has higher priority than every in-service level, so an in-service level blocks itself and all lower levels.
- R5: Mask bit i (1 = blocked) stops line i of that controller from being resolved. The request stays latched and is served once the bit is cleared.
- R6: Lines 8 to 15 reach `int_out` only through the secondary's output, which drives primary input 2. `irq_in[2]` has no effect.
- R7: The first `inta` pulse returns nothing (`vec_valid` stays 0). One cycle after the second pulse, `vec_valid` is 1 for exactly one cycle and `vec_out` = {base[7:3], level code[2:0]}, where codes 0..7 stand for lines 0..7 of the primary.
- R8: When primary input 2 wins, the vector is the secondary's base with the secondary's code (0..7 for lines 8..15), and that level is also marked in service in the secondary.
- R9: A command-address write of 0x20 clears only the highest-priority in-service bit of that controller. A cascaded interrupt needs this on both controllers before lower levels of the primary are served again.
- R10: The primary accepts only 0x04 as its link word. Any other value is refused and the primary stays waiting for the link word. The secondary accepts any link word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Write address (0x20/0x21 primary, 0xA0/0xA1 secondary) |
| wr_data | input | 8 | Write data byte |
| irq_in | input | 16 | Request lines; 0-7 primary, 8-15 secondary |
| inta | input | 1 | Acknowledge pulse, one cycle per acknowledge step |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector byte returned on the second acknowledge |
| vec_valid | output | 1 | One-cycle marker that vec_out carries a vector |

## Verification
A rising request edge registered at one clock edge raises `int_out` right after that edge, because the resolver is combinational from the latches. A mask or end-of-interrupt write likewise changes `int_out` right after the edge that accepts the write. The vector is due exactly one cycle after the edge that samples the second `inta` pulse. The driver stamps each expected vector with that cycle, and the monitor compares both the value and the cycle when `vec_valid` rises. All other checks are taken at the falling edge that follows the accepting rising edge.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_LINES = 8;
  localparam int PIC_LVL_W = $clog2(PIC_LINES);
  localparam int PIC_BASE_W = 8 - PIC_LVL_W;
  localparam int PIC_IDX_W = PIC_LVL_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_LINK = 2'd2,
    ST_RUN  = 2'd3
  } init_st_e;

  // index of the lowest set bit, PIC_LINES when none is set
  function automatic logic [PIC_IDX_W-1:0] first_set(input logic [PIC_LINES-1:0] v);
    logic [PIC_IDX_W-1:0] r;
    r = PIC_IDX_W'(PIC_LINES);
    for (int i = PIC_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = PIC_IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [7:0] make_vector(input logic [PIC_BASE_W-1:0] base,
                                             input logic [PIC_LVL_W-1:0] lvl);
    return {base, lvl};
  endfunction
endpackage

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic_pkg::*;
(
  input  logic [PIC_LINES-1:0] pend,
  input  logic [PIC_LINES-1:0] insvc,
  output logic                 win_valid,
  output logic [PIC_LVL_W-1:0] win_lvl
);
  logic [PIC_IDX_W-1:0] p_idx;
  logic [PIC_IDX_W-1:0] s_idx;

  always_comb begin
    p_idx     = first_set(pend);
    s_idx     = first_set(insvc);
    win_valid = (p_idx != PIC_IDX_W'(PIC_LINES)) && (p_idx < s_idx);
    win_lvl   = p_idx[PIC_LVL_W-1:0];
  end

  // R4: the winner is pending and nothing of higher priority is pending or in service
  always_comb begin
    if (win_valid) begin
      p_win_pending_r4: assert (pend[win_lvl]);
      p_win_top_r4: assert (((pend | insvc) & ((PIC_LINES'(1) << win_lvl) - PIC_LINES'(1))) == '0);
    end
  end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pkg::*;
#(
  parameter bit HAS_CASC = 1'b0,
  parameter int CASC_LINE = 2,
  parameter logic [7:0] LINK_WORD = 8'h04
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_wr,
  input  logic                  data_wr,
  input  logic [7:0]            wdata,
  input  logic [PIC_LINES-1:0]  lines,
  input  logic                  cascade_in,
  input  logic                  ack_take,
  output logic                  int_o,
  output logic [PIC_LVL_W-1:0]  win_lvl,
  output logic [PIC_BASE_W-1:0] base_o
);
  init_st_e              st;
  logic [PIC_BASE_W-1:0] base_q;
  logic [PIC_LINES-1:0]  mask_q, irr_q, isr_q, prev_q;
  logic [PIC_LINES-1:0]  req_eff, pend, edge_set, ack_bit, eoi_bit;
  logic [PIC_IDX_W-1:0]  isr_top;
  logic                  running, init_start, eoi_hit, win_valid;

  assign running    = (st == ST_RUN);
  assign init_start = cmd_wr && wdata[4];
  assign eoi_hit    = cmd_wr && !wdata[4] && wdata[5];
  assign edge_set   = lines & ~prev_q & {PIC_LINES{running}};

  always_comb begin
    for (int i = 0; i < PIC_LINES; i++) begin
      req_eff[i] = (HAS_CASC && i == CASC_LINE) ? cascade_in : irr_q[i];
    end
    pend    = req_eff & ~mask_q & {PIC_LINES{running}};
    isr_top = first_set(isr_q);
    eoi_bit = (isr_top < PIC_IDX_W'(PIC_LINES)) ? (PIC_LINES'(1) << isr_top[PIC_LVL_W-1:0]) : '0;
    ack_bit = ack_take ? (PIC_LINES'(1) << win_lvl) : '0;
  end

  pic_resolver u_res (
    .pend     (pend),
    .insvc    (isr_q),
    .win_valid(win_valid),
    .win_lvl  (win_lvl)
  );

  assign int_o  = win_valid;
  assign base_o = base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      base_q <= '0;
      mask_q <= '1;
      irr_q  <= '0;
      isr_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= lines;
      if (init_start) begin
        st     <= ST_BASE;
        mask_q <= '0;
        irr_q  <= '0;
        isr_q  <= '0;
      end else begin
        irr_q <= (irr_q & ~ack_bit) | edge_set;
        isr_q <= (isr_q & ~(eoi_hit ? eoi_bit : '0)) | ack_bit;
        if (data_wr) begin
          case (st)
            ST_BASE: begin
              base_q <= wdata[7:PIC_LVL_W];
              st     <= ST_LINK;
            end
            ST_LINK: if (!HAS_CASC || wdata == LINK_WORD) st <= ST_RUN;
            ST_RUN:  mask_q <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  p_quiet_before_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> running);

  p_ack_marks_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !init_start) |=> isr_q[$past(win_lvl)]);

  p_eoi_drops_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !ack_take && isr_q != '0) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/cascade_pic_top.sv
module cascade_pic_top
  import pic_pkg::*;
#(
  parameter logic [7:0] PRI_CMD   = 8'h20,
  parameter logic [7:0] PRI_DATA  = 8'h21,
  parameter logic [7:0] SEC_CMD   = 8'hA0,
  parameter logic [7:0] SEC_DATA  = 8'hA1,
  parameter int         CASC_LINE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [15:0] irq_in,
  input  logic        inta,
  output logic        int_out,
  output logic [7:0]  vec_out,
  output logic        vec_valid
);
  localparam logic [7:0] LINK_PRI = 8'(1) << CASC_LINE;

  logic                  p_int, s_int, p_take, s_take;
  logic [PIC_LVL_W-1:0]  p_lvl, s_lvl, lvl_hold;
  logic [PIC_BASE_W-1:0] p_base, s_base;
  logic                  ack_phase, first_ack, second_ack, sel_sec;

  assign first_ack  = inta && !ack_phase;
  assign second_ack = inta && ack_phase;
  assign p_take     = first_ack && p_int;
  assign s_take     = p_take && (p_lvl == PIC_LVL_W'(CASC_LINE));

  pic_unit #(.HAS_CASC(1'b1), .CASC_LINE(CASC_LINE), .LINK_WORD(LINK_PRI)) u_pri (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (wr_en && wr_addr == PRI_CMD),
    .data_wr   (wr_en && wr_addr == PRI_DATA),
    .wdata     (wr_data),
    .lines     (irq_in[7:0]),
    .cascade_in(s_int),
    .ack_take  (p_take),
    .int_o     (p_int),
    .win_lvl   (p_lvl),
    .base_o    (p_base)
  );

  pic_unit #(.HAS_CASC(1'b0), .CASC_LINE(CASC_LINE), .LINK_WORD(LINK_PRI)) u_sec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (wr_en && wr_addr == SEC_CMD),
    .data_wr   (wr_en && wr_addr == SEC_DATA),
    .wdata     (wr_data),
    .lines     (irq_in[15:8]),
    .cascade_in(1'b0),
    .ack_take  (s_take),
    .int_o     (s_int),
    .win_lvl   (s_lvl),
    .base_o    (s_base)
  );

  assign int_out = p_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_phase <= 1'b0;
      sel_sec   <= 1'b0;
      lvl_hold  <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      if (inta) ack_phase <= !ack_phase;
      if (first_ack) begin
        sel_sec  <= s_take;
        lvl_hold <= !p_int ? '1 : (s_take ? s_lvl : p_lvl);
      end
      vec_valid <= second_ack;
      if (second_ack) vec_out <= make_vector(sel_sec ? s_base : p_base, lvl_hold);
    end
  end

  p_first_ack_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    first_ack |=> !vec_valid);

  p_second_ack_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
    second_ack |=> vec_valid);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  p_cascade_via_sec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_take |-> s_int);

  p_sec_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (second_ack && sel_sec) |=> (vec_out[7:PIC_LVL_W] == $past(s_base)));
endmodule

// File: tb/cascade_pic_top_tb.sv
module cascade_pic_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] irq_in = '0;
  logic        inta = 1'b0;
  logic        int_out;
  logic [7:0]  vec_out;
  logic        vec_valid;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] v;
    int         due;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cascade_pic_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_in(irq_in), .inta(inta), .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // driver: two acknowledge pulses, expected vector queued for the monitor
  task automatic ack(input logic [7:0] v, input string tag);
    exp_t e;
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    chk({tag, " R7 first ack silent"}, {7'd0, vec_valid}, 8'd0);
    @(negedge clk);
    e.v = v; e.due = cyc + 1; e.tag = tag;
    exp_q.push_back(e);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R7 unexpected vector got=%h exp=none", vec_out);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (vec_out !== e.v || cyc != e.due) begin
          failures++;
          $display("FAIL %s vector got=%h@%0d exp=%h@%0d", e.tag, vec_out, cyc, e.v, e.due);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state and no interrupt before init
    chk("R1 int_out after reset", {7'd0, int_out}, 8'd0);
    chk("R1 vec_valid after reset", {7'd0, vec_valid}, 8'd0);
    irq_in[3] = 1'b1; settle(); settle();
    chk("R1 no int before init", {7'd0, int_out}, 8'd0);
    irq_in[3] = 1'b0; settle();

    // R2 primary init, base write with nonzero low bits
    wr(8'h20, 8'h11);
    wr(8'h21, 8'h0B);
    // R10 wrong link word refused
    wr(8'h21, 8'h05);
    irq_in[0] = 1'b1; settle();
    chk("R10 bad link word keeps primary idle", {7'd0, int_out}, 8'd0);
    irq_in[0] = 1'b0; settle();
    wr(8'h21, 8'h04);
    wr(8'h21, 8'h00);
    // secondary init (any link word)
    wr(8'hA0, 8'h11);
    wr(8'hA1, 8'h70);
    wr(8'hA1, 8'h02);
    wr(8'hA1, 8'h00);

    // R3 edge latch, R2 base low bits dropped
    irq_in[3] = 1'b1; settle();
    chk("R3 edge raises int", {7'd0, int_out}, 8'd1);
    ack(8'h0B, "R2 base bits[2:0] dropped");
    wr(8'h20, 8'h20);
    chk("R3 held line no re-request", {7'd0, int_out}, 8'd0);
    irq_in[3] = 1'b0; settle();

    // R4 fixed priority and in-service blocking
    irq_in[5] = 1'b1; irq_in[1] = 1'b1; settle();
    chk("R4 two pending", {7'd0, int_out}, 8'd1);
    ack(8'h09, "R4 line1 beats line5");
    chk("R4 in-service blocks lower", {7'd0, int_out}, 8'd0);
    wr(8'h20, 8'h20);
    chk("R9 eoi releases line5", {7'd0, int_out}, 8'd1);
    ack(8'h0D, "R4 line5 served");
    wr(8'h20, 8'h20);
    irq_in = '0; settle();

    // R5 mask
    wr(8'h21, 8'h10);
    irq_in[4] = 1'b1; settle();
    chk("R5 masked line quiet", {7'd0, int_out}, 8'd0);
    wr(8'h21, 8'h00);
    chk("R5 unmask serves latched", {7'd0, int_out}, 8'd1);
    ack(8'h0C, "R5 line4 vector");
    wr(8'h20, 8'h20);
    irq_in = '0; settle();

    // R6 primary line 2 has no effect
    irq_in[2] = 1'b1; settle(); settle();
    chk("R6 irq_in[2] ignored", {7'd0, int_out}, 8'd0);
    irq_in[2] = 1'b0; settle();

    // R8 cascade vector
    irq_in[10] = 1'b1; settle();
    chk("R6 secondary reaches int_out", {7'd0, int_out}, 8'd1);
    ack(8'h72, "R8 line10 vector");
    chk("R8 cascade in service", {7'd0, int_out}, 8'd0);
    wr(8'hA0, 8'h20);
    wr(8'h20, 8'h20);
    irq_in = '0; settle();

    irq_in[15] = 1'b1; irq_in[8] = 1'b1; settle();
    ack(8'h70, "R8 line8 beats line15");
    wr(8'hA0, 8'h20);
    chk("R9 primary level2 still in service", {7'd0, int_out}, 8'd0);
    wr(8'h20, 8'h20);
    chk("R9 both eoi release line15", {7'd0, int_out}, 8'd1);
    ack(8'h77, "R8 line15 vector");
    wr(8'hA0, 8'h20);
    wr(8'h20, 8'h20);
    irq_in = '0; settle();

    // R9 nested service, eoi clears highest only
    irq_in[6] = 1'b1; settle();
    ack(8'h0E, "R9 line6 vector");
    irq_in[4] = 1'b1; settle();
    chk("R4 higher line nests", {7'd0, int_out}, 8'd1);
    ack(8'h0C, "R9 nested line4 vector");
    irq_in[7] = 1'b1; settle();
    chk("R4 line7 blocked", {7'd0, int_out}, 8'd0);
    wr(8'h20, 8'h20);
    chk("R9 eoi cleared only line4", {7'd0, int_out}, 8'd0);
    wr(8'h20, 8'h20);
    chk("R9 second eoi frees line7", {7'd0, int_out}, 8'd1);
    ack(8'h0F, "R9 line7 vector");
    wr(8'h20, 8'h20);
    irq_in = '0;
    repeat (4) settle();

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R7 missing vectors got=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule